// File: doc/BRIEF.md
# Programmable Parallel Port with Per-Bit Direction

This block is a bank of general-purpose parallel pins, sized at eight by default, controlled over a small register bus. Each pin has two stored bits: an output latch, which holds the level the pin drives, and a direction bit, which turns the pin's output driver on. Software reaches both through two register offsets. It can read back the direction register, and it can read a data view whose source is chosen when the block is built.

With the pin-level read-back variant, a data read returns the sampled level of every pin, whatever its direction. With the latched read-back variant, a data read returns the latch contents for bits set as outputs and the sampled pin level for bits set as inputs. The output latch accepts writes at all times. This lets software load the level it wants before it turns a driver on, so no pin dips to the reset level on the way to being an output. The pad itself is outside the block: the block presents the latch, the enable and the sampled pin level as separate signals.

Top module: `pio_bank`

## Requirements
- R1: While reset is held and after it is released, the output latch and the direction register are all zeros, so `pin_out` and `pin_oe` are both zero. Reading offset 1 then returns zero.
- R2: A write (`bus_we`=1) to offset 0 loads `bus_wdata` into the output latch at that clock edge, whatever the direction bits hold. `pin_out` shows the new value from the next cycle.
- R3: A write to offset 1 loads the direction register. From the next cycle, `pin_oe[i]` is 1 exactly when direction bit i is 1 (1 = output, 0 = input).
- R4: Reads are registered. `bus_rdata` in cycle n+1 reflects the offset presented on `bus_addr` in cycle n. Offset 1 returns the direction register.
- R5: With `READ_LATCHED`=0, reading offset 0 returns the sampled `pin_in` for every bit, including bits that are outputs.
- R6: With `READ_LATCHED`=1, reading offset 0 returns the output latch for bits whose direction bit is 1 and `pin_in` for bits whose direction bit is 0. This holds even when `pin_in` disagrees with the latch.
- R7: When a read and a write target the same offset in the same cycle, `bus_rdata` in the next cycle shows the register value from before the write.
- R8: Offsets 2 and above read as zero, and writes to them change neither register.
- R9: If a high level is written to the latch before the direction bit is set, the pad (pulled high while undriven) never reads low during the change to output.
- R10: While `bus_we` is 0, neither register changes, whatever `bus_wdata` and `bus_addr` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset (0 data, 1 direction) |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | WIDTH | Write value |
| bus_rdata | output | WIDTH | Registered read value for the previous cycle's offset |
| pin_in | input | WIDTH | Sampled pin levels |
| pin_out | output | WIDTH | Output latch contents |
| pin_oe | output | WIDTH | Per-bit output driver enable |

## Verification
The bus carries one offset per cycle, and that offset serves both the read and any write, so a register can be read and overwritten in the same cycle. The bench provokes this by raising the write strobe while the offset points at the data register, and then at the direction register. It expects `bus_rdata` in the following cycle to hold the old contents while `pin_out` or `pin_oe` already shows the new value. A second overlap is a write to the data latch while the affected bits are inputs. The bench checks that the pins stay undriven, and that the value then appears on the pads without a dip when the direction is switched.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_DIR  = 1;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_NONE = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
   import pio_pkg::*;
#(
   parameter int unsigned ADDR_W = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output reg_sel_e          sel,
   output logic              wr_data,
   output logic              wr_dir
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

   always_comb begin
      if (addr == A_DATA)     sel = SEL_DATA;
      else if (addr == A_DIR) sel = SEL_DIR;
      else                    sel = SEL_NONE;
   end

   assign wr_data = we && (sel == SEL_DATA);
   assign wr_dir  = we && (sel == SEL_DIR);
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q
);
   // Output latch: loaded on every data write, independent of direction.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (wr_data) data_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end

   assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> data_q == $past(wdata));
   assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(wdata));
   assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(data_q));
   assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/pio_rdpath.sv
module pio_rdpath
   import pio_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter bit          READ_LATCHED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] rd_q
);
   logic [WIDTH-1:0] data_view;

   generate
      if (READ_LATCHED) begin : g_latched
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign data_view[i] = dir_q[i] ? data_q[i] : pin_in[i];
         end
         assert_rd_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SEL_DATA) |=>
               ((rd_q & $past(dir_q)) == ($past(data_q) & $past(dir_q))) &&
               ((rd_q & ~$past(dir_q)) == ($past(pin_in) & ~$past(dir_q))));
      end else begin : g_pinlevel
         assign data_view = pin_in;
         assert_rd_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SEL_DATA) |=> rd_q == $past(pin_in));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else begin
         unique case (sel)
            SEL_DATA: rd_q <= data_view;
            SEL_DIR:  rd_q <= dir_q;
            default:  rd_q <= '0;
         endcase
      end
   end

   assert_rd_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DIR) |=> rd_q == $past(dir_q));
   assert_rd_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |=> rd_q == '0);
endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned ADDR_W       = 2,
   parameter bit          READ_LATCHED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   generate
      if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
         $error("pio_bank: WIDTH out of range");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("pio_bank: ADDR_W out of range");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_data, wr_dir;
   logic [WIDTH-1:0] data_q, dir_q;

   pio_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr    (bus_addr),
      .we      (bus_we),
      .sel     (sel),
      .wr_data (wr_data),
      .wr_dir  (wr_dir)
   );

   pio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data),
      .wr_dir  (wr_dir),
      .wdata   (bus_wdata),
      .data_q  (data_q),
      .dir_q   (dir_q)
   );

   pio_rdpath #(.WIDTH(WIDTH), .READ_LATCHED(READ_LATCHED)) u_rdpath (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .data_q (data_q),
      .dir_q  (dir_q),
      .pin_in (pin_in),
      .rd_q   (bus_rdata)
   );

   assign pin_out = data_q;
   assign pin_oe  = dir_q;

   // A driver can only switch on through a direction write.
   assert_oe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && sel == SEL_DIR) |=> $stable(pin_oe));
endmodule

// File: tb/pio_bank_tb.sv
module pio_bank_tb;
   localparam int W = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  ext = '0;
   logic [W-1:0]  rd_a, rd_b, out_a, out_b, oe_a, oe_b;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   int glitches = 0;

   always #5 clk = ~clk;

   pio_bank #(.WIDTH(W), .ADDR_W(AW), .READ_LATCHED(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pin_in(ext),
      .pin_out(out_a), .pin_oe(oe_a));

   pio_bank #(.WIDTH(W), .ADDR_W(AW), .READ_LATCHED(1'b1)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(ext),
      .pin_out(out_b), .pin_oe(oe_b));

   // Pad model: pulled high when not driven.
   logic [W-1:0] pad;
   assign pad = (oe_a & out_a) | ~oe_a;

   always @(negedge clk) begin
      if (mon_en && pad != 8'hFF) glitches++;
   end

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] v);
      bus_addr = a; bus_we = 1'b1; bus_wdata = v;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      bus_addr = a; bus_we = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] m_data, m_dir;
      ext = 8'h6B;
      repeat (3) @(negedge clk);
      check("R1 pin_out in reset", out_a, 8'h00);
      check("R1 pin_oe in reset", oe_b, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd1);
      check("R1 dir after reset", rd_a, 8'h00);
      rd(2'd0);
      check("R1 latched view after reset (all inputs)", rd_b, 8'h6B);

      // R2: latch loads while bits are inputs, drivers stay off
      wr(2'd0, 8'hA5);
      check("R2 pin_out after write with dir=0", out_a, 8'hA5);
      check("R2 pin_oe unchanged", oe_a, 8'h00);

      // R9: high data loaded first, then direction switched; pad must never dip
      wr(2'd0, 8'hFF);
      mon_en = 1'b1;
      wr(2'd1, 8'hFF);
      rd(2'd0);
      mon_en = 1'b0;
      check("R9 pad high after switch", pad, 8'hFF);
      check("R9 no low glitch seen", W'(glitches), 8'h00);

      // Sweep all direction patterns
      for (int d = 0; d < 256; d++) begin
         m_dir  = W'(d);
         m_data = W'(d) ^ 8'h5A;
         wr(2'd0, m_data);
         wr(2'd1, m_dir);
         check("R3 pin_oe follows direction", oe_b, m_dir);
         check("R2 pin_out follows latch", out_b, m_data);
         ext = {W'(d)} ^ 8'hC3;
         ext = {ext[3:0], ext[7:4]};
         rd(2'd0);
         check("R5 pin-level read", rd_a, ext);
         check("R6 latched read", rd_b, (m_data & m_dir) | (ext & ~m_dir));
         rd(2'd1);
         check("R4 direction read", rd_b, m_dir);
      end

      // R6 conflict: pins held opposite to the latch
      wr(2'd1, 8'hFF);
      wr(2'd0, 8'h3C);
      ext = 8'hC3;
      rd(2'd0);
      check("R6 outputs read latch under conflict", rd_b, 8'h3C);
      check("R5 outputs read pin under conflict", rd_a, 8'hC3);

      // R7: read and write of the same offset in one cycle
      bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'h99;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      check("R7 data read shows pre-write value", rd_b, 8'h3C);
      check("R7 latch already updated", out_b, 8'h99);
      rd(2'd0);
      check("R7 data read shows new value next", rd_b, 8'h99);
      bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 8'h0F;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
      check("R7 dir read shows pre-write value", rd_a, 8'hFF);
      check("R7 pin_oe already updated", oe_a, 8'h0F);

      // R8: unmapped offsets
      wr(2'd2, 8'h12);
      wr(2'd3, 8'h34);
      check("R8 latch untouched", out_a, 8'h99);
      check("R8 direction untouched", oe_a, 8'h0F);
      rd(2'd2);
      check("R8 offset 2 reads zero", rd_b, 8'h00);
      rd(2'd3);
      check("R8 offset 3 reads zero", rd_a, 8'h00);

      // R10: strobe low, data on bus
      bus_addr = 2'd0; bus_wdata = 8'h00;
      @(posedge clk); @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'hF0;
      @(posedge clk); @(negedge clk);
      check("R10 latch holds without strobe", out_b, 8'h99);
      check("R10 direction holds without strobe", oe_b, 8'h0F);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule